// File: doc/BRIEF.md
# Noise-Shaped Reference Delay Dither Controller

This block drives the enables of a chain of seven identical delay cells placed in the path of a reference clock. Each reference cycle it chooses how many cells are switched in. Over time this moves the reference edge with a dither pattern whose spectrum is pushed to high offset frequencies. The result is that the reference carries a large amount of jitter while adding little noise inside the loop bandwidth. A phase-locked loop with a one-bit early/late phase detector can use this to linearize its detector and to set its loop bandwidth.

A third-order modulator runs on the reference clock. It is built from three cascaded first-order accumulators, with digital noise cancellation that recombines their carries. It turns a programmable fractional word into a cell count from 0 to 7. The count leaves the block as a thermometer code.

The delay cells are all alike, so no element-mismatch shaping is needed. A two-bit code that sets the per-cell delay is registered alongside the enables. When the dither is switched off, every cell is bypassed and the modulator state is held at zero.

Top module: `dly_dither_ctrl`

## Requirements
- R1: While rst_ni is low, stage_en_o and range_o are all zero and every accumulator and carry history register is zero.
- R2: stage_en_o is always a thermometer code: bit i (the enable of cell i+1) is high exactly when the registered count exceeds i, so cells 1..k are on for count k.
- R3: On each rising clock edge with dither_en_i high, three 8-bit accumulators update in cascade. The first adds frac_i; the second adds the first's new value; the third adds the second's new value. Each produces carry c1, c2, c3. The registered count becomes 3 + c1 + (c2 - c2') + (c3 - 2*c3' + c3''), where ' and '' are the values of that carry one and two enabled edges earlier.
- R4: The count is clamped to 0..7. At the default order the unclamped value spans -3..+4, so after the offset of 3 every code from 0 to 7 is reachable and the clamp never engages.
- R5: On a rising edge with dither_en_i low, stage_en_o becomes all zero and the accumulators and carry histories clear. The next enabled edge then behaves exactly as the first enabled edge after reset.
- R6: range_o takes the value of range_i on every rising edge, whether the dither is on or off. The codes run from 11 (shortest delay per cell) through 10 and 01 to 00 (longest).
- R7: Starting from cleared state, with frac_i held constant for 256 enabled cycles, the number of enabled cells summed over those cycles lies between 768 + frac_i - 1 and 768 + frac_i + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; all state updates on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dither_en_i | input | 1 | High: modulate the delay; low: bypass all cells and clear state |
| frac_i | input | 8 | Fractional delay word, in units of 1/256 cell |
| range_i | input | 2 | Per-cell delay range code |
| stage_en_o | output | 7 | Thermometer-coded delay cell enables, bit 0 for cell 1 |
| range_o | output | 2 | Registered per-cell delay range code |

## Verification
A disable can arrive in the same reference cycle as a change of range code, or as a carry out of the third accumulator. The enables must then collapse to zero while the range code still follows its input, and the cleared state must hold for the next enable. The random stimulus draws the enable, the fractional word and the range code independently on every cycle, so these coincidences occur often. A directed step also forces a disable and a range change together. Each cycle is judged against a bench model of the cascaded accumulators and their carry histories, together with a separate check on the range register.

// File: rtl/dly_dither_pkg.sv
package dly_dither_pkg;

  localparam int unsigned DEF_FRAC_W   = 8;
  localparam int unsigned DEF_N_STAGES = 7;
  localparam int unsigned DEF_ORDER    = 3;

  // binomial coefficient, used to build the (1 - z^-1)^k cancellation taps
  function automatic int binom(int n, int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) r = (r * (n - i)) / (i + 1);
    return r;
  endfunction

endpackage

// File: rtl/dly_dither_accum.sv
module dly_dither_accum #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] add_i,
  output logic [W-1:0] acc_next_o,
  output logic         carry_o,
  output logic [W-1:0] acc_o
);

  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum        = {1'b0, acc_q} + {1'b0, add_i};
  assign acc_next_o = sum[W-1:0];
  assign carry_o    = sum[W];
  assign acc_o      = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (!en_i) acc_q <= '0;
    else            acc_q <= sum[W-1:0];
  end

endmodule

// File: rtl/dly_dither_cancel.sv
module dly_dither_cancel
  import dly_dither_pkg::*;
#(
  parameter int unsigned ORDER    = 3,
  parameter int unsigned N_STAGES = 7,
  parameter int unsigned CNT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ORDER-1:0] carry_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int TW     = ORDER + 2;
  localparam int OFFSET = (1 << (ORDER - 1)) - 1;

  logic [ORDER-1:0][TW-1:0] term;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_direct
      assign term[k] = TW'(carry_i[k]);
    end else begin : g_diff
      logic [k-1:0] dl_q;
      int           t_v;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dl_q <= '0;
        else if (!en_i) dl_q <= '0;
        else begin
          dl_q[0] <= carry_i[k];
          for (int j = 1; j < k; j++) dl_q[j] <= dl_q[j-1];
        end
      end

      // k-th order difference of this stage's carry
      always_comb begin
        t_v = int'(carry_i[k]);
        for (int j = 1; j <= k; j++) begin
          if ((j % 2) != 0) t_v = t_v - binom(k, j) * int'(dl_q[j-1]);
          else              t_v = t_v + binom(k, j) * int'(dl_q[j-1]);
        end
      end

      assign term[k] = TW'(t_v);
    end
  end

  int raw;

  always_comb begin
    raw = OFFSET;
    for (int k = 0; k < ORDER; k++) raw = raw + int'($signed(term[k]));
    if (raw < 0)                  cnt_o = '0;
    else if (raw > int'(N_STAGES)) cnt_o = CNT_W'(N_STAGES);
    else                          cnt_o = CNT_W'(raw);
  end

endmodule

// File: rtl/dly_dither_therm.sv
module dly_dither_therm #(
  parameter int unsigned N_STAGES = 7,
  parameter int unsigned CNT_W    = 3
) (
  input  logic [CNT_W-1:0]    cnt_i,
  output logic [N_STAGES-1:0] therm_o
);

  for (genvar i = 0; i < N_STAGES; i++) begin : g_bit
    assign therm_o[i] = (cnt_i > CNT_W'(i));
  end

endmodule

// File: rtl/dly_dither_ctrl.sv
module dly_dither_ctrl
  import dly_dither_pkg::*;
#(
  parameter int unsigned FRAC_W   = DEF_FRAC_W,
  parameter int unsigned N_STAGES = DEF_N_STAGES,
  parameter int unsigned ORDER    = DEF_ORDER
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dither_en_i,
  input  logic [FRAC_W-1:0]   frac_i,
  input  logic [1:0]          range_i,
  output logic [N_STAGES-1:0] stage_en_o,
  output logic [1:0]          range_o
);

  localparam int unsigned CNT_W = $clog2(N_STAGES + 1);

  logic [ORDER-1:0][FRAC_W-1:0] acc_next;
  logic [ORDER-1:0][FRAC_W-1:0] acc_st;
  logic [ORDER-1:0]             carry;
  logic [CNT_W-1:0]             cnt;
  logic [N_STAGES-1:0]          therm;
  logic [N_STAGES-1:0]          stage_en_q;
  logic [1:0]                   range_q;

  for (genvar k = 0; k < ORDER; k++) begin : g_acc
    logic [FRAC_W-1:0] add;
    if (k == 0) begin : g_head
      assign add = frac_i;
    end else begin : g_chain
      assign add = acc_next[k-1];
    end

    dly_dither_accum #(.W(FRAC_W)) i_accum (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (dither_en_i),
      .add_i      (add),
      .acc_next_o (acc_next[k]),
      .carry_o    (carry[k]),
      .acc_o      (acc_st[k])
    );
  end

  dly_dither_cancel #(
    .ORDER    (ORDER),
    .N_STAGES (N_STAGES),
    .CNT_W    (CNT_W)
  ) i_cancel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (dither_en_i),
    .carry_i (carry),
    .cnt_o   (cnt)
  );

  dly_dither_therm #(
    .N_STAGES (N_STAGES),
    .CNT_W    (CNT_W)
  ) i_therm (
    .cnt_i   (cnt),
    .therm_o (therm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_en_q <= '0;
      range_q    <= '0;
    end else begin
      stage_en_q <= dither_en_i ? therm : '0;
      range_q    <= range_i;
    end
  end

  assign stage_en_o = stage_en_q;
  assign range_o    = range_q;

endmodule

// File: rtl/dly_dither_chk.sv
module dly_dither_chk #(
  parameter int unsigned FRAC_W   = 8,
  parameter int unsigned N_STAGES = 7,
  parameter int unsigned ORDER    = 3
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         dither_en_i,
  input logic [1:0]                   range_i,
  input logic [N_STAGES-1:0]          stage_en_o,
  input logic [1:0]                   range_o,
  input logic [ORDER-1:0][FRAC_W-1:0] acc_i
);

  assert_thermo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stage_en_o + 1'b1) & stage_en_o) == '0);

  assert_off_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dither_en_i |=> stage_en_o == '0);

  assert_acc_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dither_en_i |=> acc_i == '0);

  assert_range_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> range_o == $past(range_i));

endmodule

bind dly_dither_ctrl dly_dither_chk #(
  .FRAC_W   (FRAC_W),
  .N_STAGES (N_STAGES),
  .ORDER    (ORDER)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dither_en_i (dither_en_i),
  .range_i     (range_i),
  .stage_en_o  (stage_en_o),
  .range_o     (range_o),
  .acc_i       (acc_st)
);

// File: tb/test_dly_dither_ctrl.sv
module test_dly_dither_ctrl;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dither_en_i = 1'b0;
  logic [7:0] frac_i = '0;
  logic [1:0] range_i = '0;
  logic [6:0] stage_en_o;
  logic [1:0] range_o;

  always #4 clk_i = ~clk_i;

  dly_dither_ctrl i_dly_dither_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dither_en_i (dither_en_i),
    .frac_i      (frac_i),
    .range_i     (range_i),
    .stage_en_o  (stage_en_o),
    .range_o     (range_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int m_a1 = 0, m_a2 = 0, m_a3 = 0;
  int m_c2p = 0, m_c3p = 0, m_c3pp = 0;
  logic [6:0] exp_en;
  bit seen0 = 0, seen7 = 0;
  int last_cnt;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit is_therm(logic [6:0] v);
    return ((v + 7'd1) & v) == 7'd0;
  endfunction

  // model of the requirements: cascaded accumulators and carry recombination
  function automatic logic [6:0] model_step(bit en, int f);
    int s1, s2, s3, c1, c2, c3, y;
    if (!en) begin
      m_a1 = 0; m_a2 = 0; m_a3 = 0; m_c2p = 0; m_c3p = 0; m_c3pp = 0;
      return 7'd0;
    end
    s1 = m_a1 + f;          c1 = s1 >> 8; m_a1 = s1 & 255;
    s2 = m_a2 + m_a1;       c2 = s2 >> 8; m_a2 = s2 & 255;
    s3 = m_a3 + m_a2;       c3 = s3 >> 8; m_a3 = s3 & 255;
    y = 3 + c1 + (c2 - m_c2p) + (c3 - 2 * m_c3p + m_c3pp);
    if (y < 0) y = 0;
    if (y > 7) y = 7;
    m_c3pp = m_c3p; m_c3p = c3; m_c2p = c2;
    return 7'((1 << y) - 1);
  endfunction

  // drive at negedge, model the coming rising edge, check at next negedge
  task automatic step(bit en, logic [7:0] f, logic [1:0] r);
    dither_en_i = en;
    frac_i      = f;
    range_i     = r;
    exp_en      = model_step(en, int'(f));
    @(negedge clk_i);
    chk("R3 stage enables", int'(stage_en_o), int'(exp_en));
    chk("R6 range code", int'(range_o), int'(r));
    last_cnt = $countones(stage_en_o);
    if (en && last_cnt == 0) seen0 = 1;
    if (last_cnt == 7) seen7 = 1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int r;
    int sum;
    logic [7:0] mean_fr [5];
    r = $urandom(32'h1d5e_a7c3);
    mean_fr[0] = 8'd0; mean_fr[1] = 8'd1; mean_fr[2] = 8'd77;
    mean_fr[3] = 8'd128; mean_fr[4] = 8'd255;

    range_i = 2'b10;
    dither_en_i = 1'b1;
    frac_i = 8'd200;
    repeat (3) @(negedge clk_i);
    chk("R1 enables in reset", int'(stage_en_o), 0);
    chk("R1 range in reset", int'(range_o), 0);
    dither_en_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    // zero fraction: constant three cells
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 8'd0, 2'b11);
      chk("R3 zero fraction count", last_cnt, 3);
    end

    // half fraction, then disable with range change in the same cycle
    for (int i = 0; i < 40; i++) step(1'b1, 8'd128, 2'b01);
    step(1'b0, 8'd128, 2'b00);
    chk("R5 disabled enables", int'(stage_en_o), 0);
    chk("R6 range on disable", int'(range_o), 0);
    step(1'b0, 8'd99, 2'b11);
    chk("R5 disable holds", int'(stage_en_o), 0);
    // restart must match a fresh start (model cleared)
    for (int i = 0; i < 24; i++) step(1'b1, 8'd37, 2'b10);

    // mean delay over 256 cycles
    foreach (mean_fr[m]) begin
      step(1'b0, 8'd0, 2'b00);
      sum = 0;
      for (int i = 0; i < 256; i++) begin
        step(1'b1, mean_fr[m], 2'b01);
        sum += last_cnt;
      end
      n_chk++;
      if (sum < 768 + int'(mean_fr[m]) - 1 || sum > 768 + int'(mean_fr[m]) + 2) begin
        n_fail++;
        $display("FAIL R7 mean frac=%0d actual=%0d expected=%0d(-1..+2)",
                 mean_fr[m], sum, 768 + int'(mean_fr[m]));
      end
    end

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit en;
      en = ($urandom % 10) != 0;
      step(en, 8'($urandom), 2'($urandom));
      n_chk++;
      if (!is_therm(stage_en_o)) begin
        n_fail++;
        $display("FAIL R2 thermometer actual=%b expected=2^k-1", stage_en_o);
      end
    end

    chk("R4 count 0 reached", int'(seen0), 1);
    chk("R4 count 7 reached", int'(seen7), 1);

    // asynchronous reset mid-run
    step(1'b1, 8'd250, 2'b10);
    #1 rst_ni = 1'b0;
    #1;
    chk("R1 enables after async reset", int'(stage_en_o), 0);
    chk("R1 range after async reset", int'(range_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    void'(model_step(1'b0, 0));
    for (int i = 0; i < 8; i++) step(1'b1, 8'd250, 2'b01);

    summary();
    $finish;
  end

endmodule